// File: doc/BRIEF.md
# Bidirectional General-Purpose I/O Port

This block is one general-purpose I/O port of up to eight pins. Each pin has a direction bit and a bit in an output latch. The block drives the output value and output enable of a tri-state pad, and it samples the pad's input level through a two-stage synchronizer. A simple synchronous register interface gives read and write access to the direction bits and the latch.

Reading the data register returns a value that differs per bit. An input pin gives its synchronized pad level. An output pin gives the value held in its latch. Reset clears the direction bits but leaves the latch alone. Software can therefore preload the latch while a pin is still an input, then switch the pin to output so that it drives the intended level from its first cycle.

Each pin can also be taken over by a peripheral. While that pin's override enable is high, the peripheral sets both the pad value and the pad enable. When the enable drops, the pin goes back to port control. The number of implemented pins is a parameter, so narrower ports of 6 or 4 pins can be built from the same code.

Top module: `gpio_port`

## Requirements
- R1: A synchronous active-low reset clears every direction bit and the registered read data. After reset, `pad_oe` is all zero and a read of the direction register returns 0.
- R2: Reset does not change the output latch. A value written before reset appears on `pad_out` after reset, and it is driven once the pin is made an output.
- R3: A write with `reg_sel`=1 loads the direction bits from `wdata`. A direction bit of 1 makes that pin an output (`pad_oe`=1 while no override is active), and 0 makes it an input.
- R4: A write with `reg_sel`=0 always loads the latch, whatever the direction. The latch reaches `pad_out` in the cycle after the write, but the pin is driven only where `pad_oe` is 1. The latch keeps its value when no data write occurs.
- R5: A read with `reg_sel`=0 returns the latch bit for each output pin and the synchronized pad level for each input pin.
- R6: A read with `reg_sel`=1 returns the stored direction bits.
- R7: Bit positions at or above the number of implemented pins read as 0 in both registers, and writes to them are ignored.
- R8: Pad input goes through a two-flop synchronizer. A level change is not returned by reads whose strobe falls on the first or second clock edge after the change. It is returned from the third edge on.
- R9: `rdata` is registered. It updates on the edge that samples `rd_en` and holds its value while `rd_en` is low.
- R10: While `alt_en[i]` is 1, `pad_out[i]` equals `alt_out[i]` and `pad_oe[i]` equals `alt_oe[i]`. While it is 0, the pin follows the latch and its direction bit. Each pin's override is independent of the others.
- R11: The peripheral override does not alter the stored direction bits or the latch. After the override is released, read-back and pad control show the earlier register values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 = data latch, 1 = direction register |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Registered read data |
| pad_in | input | PIN_W | Pad input levels (asynchronous) |
| pad_out | output | PIN_W | Pad output values |
| pad_oe | output | PIN_W | Pad output enables |
| alt_en | input | PIN_W | Per-pin peripheral override enable |
| alt_out | input | PIN_W | Peripheral output values |
| alt_oe | input | PIN_W | Peripheral output enables |

## Verification
The bench builds the port with an 8-bit bus and 6 implemented pins. This configuration makes the two unimplemented upper bit positions visible on the bus, so R7 is checked. With only 6 pins, all 64 direction patterns can be swept, and so can all 64 override-enable patterns. Each sweep runs against latch and pad values derived from the pattern number, which exercises every mix of input and output pins in the read-back.

// File: rtl/gpio_pkg.sv
// Shared definitions for the general-purpose I/O port.
// Assumes a single-bit register select on the bus.
package gpio_pkg;
    typedef enum logic {
        REG_DATA = 1'b0,
        REG_DIR  = 1'b1
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer, one chain per pin.
// Assumes pad inputs are asynchronous to clk; reset clears both stages.
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Purpose: move the pad levels into the clock domain over two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_regs.sv
// Direction register, output latch and registered read-back.
// Assumes PIN_W <= BUS_W. Bus bits at or above PIN_W are dropped on write
// and read as zero. The latch has no reset on purpose.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  gpio_reg_e        reg_sel,
    input  logic [BUS_W-1:0] wdata,
    input  logic [PIN_W-1:0] pin_sync,
    output logic [PIN_W-1:0] dir_q,
    output logic [PIN_W-1:0] latch_q,
    output logic [BUS_W-1:0] rdata
);
    logic [PIN_W-1:0] wr_bits;
    logic [PIN_W-1:0] data_view;
    logic [BUS_W-1:0] rd_next;

    assign wr_bits = wdata[PIN_W-1:0];

    // Purpose: direction bits, cleared by reset, loaded on a direction write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr_en && reg_sel == REG_DIR)
            dir_q <= wr_bits;
    end

    // Purpose: output latch, unaffected by reset, loaded on a data write.
    always_ff @(posedge clk) begin
        if (wr_en && reg_sel == REG_DATA)
            latch_q <= wr_bits;
    end

    // Purpose: choose the per-bit read-back source for the data register.
    always_comb begin
        data_view = (dir_q & latch_q) | (~dir_q & pin_sync);
        rd_next   = (reg_sel == REG_DIR) ? BUS_W'(dir_q) : BUS_W'(data_view);
    end

    // Purpose: register read data on the read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_next;
    end

    assert_dir_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> dir_q == '0);

    assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == REG_DIR) |=> dir_q == $past(wdata[PIN_W-1:0]));

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(latch_q));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    assert_rdata_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel == REG_DIR && !wr_en) |=> rdata == BUS_W'($past(dir_q)));
endmodule

// File: rtl/gpio_pinmux.sv
// Per-pin selection between port control and peripheral override.
// Assumes alt_en is held high for as long as the peripheral owns the pin.
module gpio_pinmux #(
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] dir_q,
    input  logic [PIN_W-1:0] latch_q,
    input  logic [PIN_W-1:0] alt_en,
    input  logic [PIN_W-1:0] alt_out,
    input  logic [PIN_W-1:0] alt_oe,
    output logic [PIN_W-1:0] pad_out,
    output logic [PIN_W-1:0] pad_oe
);
    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        // Purpose: the peripheral owns the pin while its enable is high.
        assign pad_out[i] = alt_en[i] ? alt_out[i] : latch_q[i];
        assign pad_oe[i]  = alt_en[i] ? alt_oe[i]  : dir_q[i];
    end

    assert_oe_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && alt_en == '0) |-> pad_oe == '0);
endmodule

// File: rtl/gpio_port.sv
// General-purpose I/O port top level: synchronizer, registers, pin mux.
// Assumes PIN_W between 1 and BUS_W; registers are accessed through a
// single-cycle write strobe and a read strobe with one cycle of latency.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             reg_sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic [PIN_W-1:0] pad_in,
    output logic [PIN_W-1:0] pad_out,
    output logic [PIN_W-1:0] pad_oe,
    input  logic [PIN_W-1:0] alt_en,
    input  logic [PIN_W-1:0] alt_out,
    input  logic [PIN_W-1:0] alt_oe
);
    logic [PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0] dir_q;
    logic [PIN_W-1:0] latch_q;
    gpio_reg_e        sel;

    assign sel = gpio_reg_e'(reg_sel);

    gpio_sync #(.WIDTH(PIN_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(.BUS_W(BUS_W), .PIN_W(PIN_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .reg_sel  (sel),
        .wdata    (wdata),
        .pin_sync (pin_sync),
        .dir_q    (dir_q),
        .latch_q  (latch_q),
        .rdata    (rdata)
    );

    gpio_pinmux #(.PIN_W(PIN_W)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_q   (dir_q),
        .latch_q (latch_q),
        .alt_en  (alt_en),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assert_oe_after_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel && alt_en == '0) |=>
            (alt_en != '0 || pad_oe == $past(wdata[PIN_W-1:0])));
endmodule

// File: tb/tb_gpio_port.sv
// Self-checking bench: 8-bit bus, 6 implemented pins, exhaustive sweeps.
module tb_gpio_port;
    localparam int CLK_PERIOD = 10;
    localparam int BUS_W = 8;
    localparam int PIN_W = 6;
    localparam logic [PIN_W-1:0] PMASK = '1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic             reg_sel = 1'b0;
    logic [BUS_W-1:0] wdata = '0;
    logic [BUS_W-1:0] rdata;
    logic [PIN_W-1:0] pad_in = '0;
    logic [PIN_W-1:0] pad_out;
    logic [PIN_W-1:0] pad_oe;
    logic [PIN_W-1:0] alt_en = '0;
    logic [PIN_W-1:0] alt_out = '0;
    logic [PIN_W-1:0] alt_oe = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port #(.BUS_W(BUS_W), .PIN_W(PIN_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .alt_en(alt_en), .alt_out(alt_out), .alt_oe(alt_oe)
    );

    task automatic check(input string req, input logic [BUS_W-1:0] got,
                         input logic [BUS_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [BUS_W-1:0] val);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wdata = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic sel, output logic [BUS_W-1:0] val);
        @(negedge clk);
        rd_en = 1'b1; reg_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
        val = rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [BUS_W-1:0] rd;
        logic [PIN_W-1:0] lat, pin, expv;

        // R4 / R2: preload the latch before the first reset
        reg_write(1'b0, 8'h15);
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(1);
        // R1: reset state of enables and direction
        check("R1 pad_oe after reset", BUS_W'(pad_oe), '0);
        check("R1 rdata after reset", rdata, '0);
        reg_read(1'b1, rd);
        check("R1 dir read after reset", rd, '0);
        // R2: latch survives reset and appears once the pins are outputs
        check("R2 pad_out keeps latch", BUS_W'(pad_out), 8'h15);
        reg_write(1'b1, 8'h3F);
        check("R2 driven after reset", BUS_W'(pad_out & pad_oe), 8'h15);
        reg_read(1'b0, rd);
        check("R2 data read back", rd, 8'h15);

        // R7: upper bus bits are ignored and read as zero
        reg_write(1'b1, 8'hFF);
        reg_read(1'b1, rd);
        check("R7 dir upper bits", rd, 8'h3F);
        reg_write(1'b0, 8'hFF);
        reg_read(1'b0, rd);
        check("R7 data upper bits", rd, 8'h3F);
        reg_write(1'b0, 8'hC0);
        reg_read(1'b0, rd);
        check("R7 write upper only", rd, 8'h00);

        // R3 R4 R5 R6: sweep every direction pattern
        for (int d = 0; d < 64; d++) begin
            lat = PIN_W'(d ^ 8'h2A);
            pin = PIN_W'((d * 5 + 3) & 63);
            reg_write(1'b1, 8'h00);
            reg_write(1'b0, {2'b11, lat});
            // R4: latch reaches pad_out while pins are inputs, no enable
            check("R4 preload not driven", BUS_W'(pad_oe), 8'h00);
            check("R4 preload latched", BUS_W'(pad_out), BUS_W'(lat));
            pad_in = pin;
            reg_write(1'b1, BUS_W'(d));
            idle(2);
            check("R3 pad_oe follows dir", BUS_W'(pad_oe), BUS_W'(d));
            reg_read(1'b0, rd);
            expv = (PIN_W'(d) & lat) | (~PIN_W'(d) & pin);
            check("R5 mixed read-back", rd, BUS_W'(expv));
            reg_read(1'b1, rd);
            check("R6 dir read-back", rd, BUS_W'(d));
        end

        // R8: synchronizer latency on an all-input port
        reg_write(1'b1, 8'h00);
        pad_in = 6'h00;
        idle(3);
        @(negedge clk);
        pad_in = 6'h2D; rd_en = 1'b1; reg_sel = 1'b0;
        @(negedge clk);
        check("R8 first edge old", rdata, 8'h00);
        @(negedge clk);
        check("R8 second edge old", rdata, 8'h00);
        @(negedge clk);
        check("R8 third edge new", rdata, 8'h2D);
        rd_en = 1'b0;

        // R9: rdata holds while no read strobe
        pad_in = 6'h12;
        idle(4);
        check("R9 rdata held", rdata, 8'h2D);
        reg_read(1'b0, rd);
        check("R9 rdata updates on read", rd, 8'h12);

        // R10 R11: sweep every override-enable pattern
        reg_write(1'b0, 8'h0F);
        reg_write(1'b1, 8'h33);
        alt_out = 6'h39; alt_oe = 6'h16;
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            alt_en = PIN_W'(a);
            @(negedge clk);
            check("R10 pad_out mux", BUS_W'(pad_out),
                  BUS_W'((PIN_W'(a) & alt_out) | (~PIN_W'(a) & 6'h0F)));
            check("R10 pad_oe mux", BUS_W'(pad_oe),
                  BUS_W'((PIN_W'(a) & alt_oe) | (~PIN_W'(a) & 6'h33)));
        end
        alt_en = 6'h3F;
        reg_read(1'b1, rd);
        check("R11 dir kept under override", rd, 8'h33);
        @(negedge clk);
        alt_en = 6'h00;
        @(negedge clk);
        check("R11 pad_oe restored", BUS_W'(pad_oe), 8'h33);
        check("R11 pad_out restored", BUS_W'(pad_out), 8'h0F);

        // R1 again: reset mid-run clears direction, latch kept (R2)
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        @(negedge clk); rst_n = 1'b1;
        idle(1);
        check("R1 pad_oe second reset", BUS_W'(pad_oe), 8'h00);
        check("R2 latch after second reset", BUS_W'(pad_out), 8'h0F);

        finish_run();
    end
endmodule